// File: doc/BRIEF.md
# Flag-Updating Integer ALU with Condition Gate

This block does the data-processing step of a 32-bit integer datapath. It takes a first operand and a second operand that an upstream shifter has already shifted, along with that shifter's carry-out. It applies one of twelve operations and produces the result, a write enable for the destination register, and the next values of the four status flags: negative (N), zero (Z), carry (C) and overflow (V). The flags arrive on `flags_in` and leave on `flags_out`. Bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. Storing the flags is the job of the surrounding pipeline.

Every operation is guarded by a 4-bit condition code that is tested against `flags_in`. When the condition fails, nothing happens: there is no register write and the flags pass through unchanged. The compare and test operations exist only to set the flags, so they never write a result. The other operations set the flags only when `set_flags` is high.

The block is purely combinational. There are no states and no transitions, so the outputs follow the inputs within the same cycle.

Top module: `alu_flag_core`

## Requirements
- R1: The logic operations use these opcodes: AND=0 (a&b), EOR=1 (a^b), ORR=12 (a|b), MOV=13 (b), BIC=14 (a&~b) and MVN=15 (~b). For example, 0x02FA62CA BIC 0x0000FFFF gives 0x02FA0000.
- R2: The arithmetic operations use these opcodes: SUB=2 (a-b), ADD=4 (a+b) and ADC=5 (a+b+C, where C is `flags_in[1]`). All results wrap modulo 2^WIDTH.
- R3: TST=8 (a&b), TEQ=9 (a^b) and CMP=10 (a-b) keep `result_we` low. Their flags come from the value shown on `result`.
- R4: TST, TEQ and CMP always update the flags. Every other valid opcode updates the flags only when `set_flags`=1. Without an update, `flags_out` equals `flags_in`.
- R5: On an update, N is the top bit of the value and Z is 1 exactly when the value is zero.
- R6: On an update by a logic, test or move operation, C takes `shift_carry` and V keeps `flags_in[0]`.
- R7: On an update by ADD, ADC, SUB or CMP, C is the adder carry-out and V is signed overflow. For SUB and CMP, C=1 means no borrow.
- R8: The 16 condition codes are tested against `flags_in`: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always; 15 never.
- R9: When `cond_pass`=0, `result_we`=0 and `flags_out` equals `flags_in`.
- R10: Opcodes 3, 6, 7 and 11 are unused. They never write a result and never change the flags.
- R11: A flag-setting ADD on the low words followed by an ADC on the high words gives the correct double-width sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, already shifted |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Asks a non-compare operation to update the flags |
| flags_in | input | 4 | Current flags: N, Z, C, V from bit 3 down to bit 0 |
| cond | input | 4 | Condition code |
| result | output | WIDTH | Computed value |
| result_we | output | 1 | Write enable for the destination register |
| flags_out | output | 4 | Next flags |
| cond_pass | output | 1 | The condition holds |

## Verification
The assertions run on every evaluation and check the invariants that hold for any input:
- compare and test operations never write, and unused opcodes leave everything untouched (R3, R10);
- a failed condition leaves the flags unchanged (R9);
- Z and N agree with the value (R5);
- logic updates keep V (R6);
- BIC output has no bit in common with the second operand (R1);
- a subtraction of equal operands gives zero with no borrow (R7);
- code 14 always passes (R8).

The exact arithmetic is left to the bench: the carry and overflow values, the wrap-around of ADC, the truth table of every condition code and the double-width chain. The bench sweeps every opcode against every operand pair of a 4-bit instance and compares each output with values it computes itself.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_TST = 4'd8,
        OP_TEQ = 4'd9,
        OP_CMP = 4'd10,
        OP_ORR = 4'd12,
        OP_MOV = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_arith(input logic [3:0] code);
        return code == OP_ADD || code == OP_ADC || code == OP_SUB || code == OP_CMP;
    endfunction

    function automatic logic op_is_compare(input logic [3:0] code);
        return code == OP_TST || code == OP_TEQ || code == OP_CMP;
    endfunction

    function automatic logic op_is_valid(input logic [3:0] code);
        return !(code == 4'd3 || code == 4'd6 || code == 4'd7 || code == 4'd11);
    endfunction

endpackage

// File: rtl/alu_add_path.sv
module alu_add_path
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;

    always_comb begin
        b_eff = b;
        c_eff = 1'b0;
        case (op)
            OP_ADC:         c_eff = carry_in;
            OP_SUB, OP_CMP: begin
                b_eff = ~b;
                c_eff = 1'b1;
            end
            default: ;
        endcase
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + (WIDTH+1)'(c_eff);
        ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    // R7: equal operands subtract to zero with no borrow
    always_comb begin
        if ((op == OP_SUB || op == OP_CMP) && a == b)
            a_r7_equal_sub: assert (sum == '0 && cout && !ovf)
                else $error("a_r7_equal_sub");
    end

endmodule

// File: rtl/alu_bit_path.sv
module alu_bit_path
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_BIC:         res = a & ~b;
            OP_MOV:         res = b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end

    // R1: bit clear leaves no bit that the mask sets
    always_comb begin
        if (op == OP_BIC)
            a_r1_bic_disjoint: assert ((res & b) == '0)
                else $error("a_r1_bic_disjoint");
    end

endmodule

// File: rtl/alu_cond_check.sv
module alu_cond_check
    import alu_flag_pkg::*;
(
    input  logic [3:0] cond,
    input  nzcv_t      fl,
    output logic       pass
);
    always_comb begin
        case (cond)
            4'd0:    pass = fl.z;
            4'd1:    pass = !fl.z;
            4'd2:    pass = fl.c;
            4'd3:    pass = !fl.c;
            4'd4:    pass = fl.n;
            4'd5:    pass = !fl.n;
            4'd6:    pass = fl.v;
            4'd7:    pass = !fl.v;
            4'd8:    pass = fl.c && !fl.z;
            4'd9:    pass = !fl.c || fl.z;
            4'd10:   pass = fl.n == fl.v;
            4'd11:   pass = fl.n != fl.v;
            4'd12:   pass = !fl.z && (fl.n == fl.v);
            4'd13:   pass = fl.z || (fl.n != fl.v);
            4'd14:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end

    // R8: the always code passes and the never code does not
    always_comb begin
        a_r8_fixed_codes: assert ((cond != 4'd14 || pass) && (cond != 4'd15 || !pass))
            else $error("a_r8_fixed_codes");
    end

endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             shift_carry,
    input  logic [3:0]       op,
    input  logic             set_flags,
    input  logic [3:0]       flags_in,
    input  logic [3:0]       cond,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [3:0]       flags_out,
    output logic             cond_pass
);
    localparam int MSB = WIDTH - 1;

    nzcv_t            cur_fl;
    nzcv_t            nxt_fl;
    logic [WIDTH-1:0] add_sum;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] value;
    logic             add_cout;
    logic             add_ovf;
    logic             is_arith;
    logic             is_cmp;
    logic             is_valid;
    logic             do_update;

    assign cur_fl = nzcv_t'(flags_in);

    alu_add_path #(.WIDTH(WIDTH)) u_add (
        .a        (opnd_a),
        .b        (opnd_b),
        .op       (op),
        .carry_in (cur_fl.c),
        .sum      (add_sum),
        .cout     (add_cout),
        .ovf      (add_ovf)
    );

    alu_bit_path #(.WIDTH(WIDTH)) u_bit (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op),
        .res (bit_res)
    );

    alu_cond_check u_cond (
        .cond (cond),
        .fl   (cur_fl),
        .pass (cond_pass)
    );

    always_comb begin
        is_arith  = op_is_arith(op);
        is_cmp    = op_is_compare(op);
        is_valid  = op_is_valid(op);
        value     = is_arith ? add_sum : bit_res;
        do_update = cond_pass && is_valid && (is_cmp || set_flags);
        nxt_fl    = cur_fl;
        if (do_update) begin
            nxt_fl.n = value[MSB];
            nxt_fl.z = (value == '0);
            nxt_fl.c = is_arith ? add_cout : shift_carry;
            nxt_fl.v = is_arith ? add_ovf : cur_fl.v;
        end
    end

    assign result    = value;
    assign result_we = cond_pass && is_valid && !is_cmp;
    assign flags_out = nxt_fl;

    always_comb begin
        // R3: compare and test never write a result
        if (op_is_compare(op))
            a_r3_cmp_nowrite: assert (!result_we) else $error("a_r3_cmp_nowrite");
        // R9: a failed condition changes nothing
        if (!cond_pass)
            a_r9_fail_hold: assert (!result_we && flags_out == flags_in)
                else $error("a_r9_fail_hold");
        // R10: unused opcodes change nothing
        if (!op_is_valid(op))
            a_r10_unused_hold: assert (!result_we && flags_out == flags_in)
                else $error("a_r10_unused_hold");
        // R5: Z and N agree with the value whenever flags move
        if (flags_out != flags_in)
            a_r5_nz_match: assert (flags_out[2] == (result == '0) && flags_out[3] == result[MSB])
                else $error("a_r5_nz_match");
        // R6: logic operations keep V
        if (!op_is_arith(op))
            a_r6_v_keep: assert (flags_out[0] == flags_in[0]) else $error("a_r6_v_keep");
    end

endmodule

// File: tb/sim_alu_flag_core.sv
module sim_alu_flag_core;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0] a, b, res;
    logic         shc, sf, we, pass;
    logic [3:0]   op, fin, fout, cond;

    alu_flag_core #(.WIDTH(W)) u0 (
        .opnd_a(a), .opnd_b(b), .shift_carry(shc), .op(op), .set_flags(sf),
        .flags_in(fin), .cond(cond), .result(res), .result_we(we),
        .flags_out(fout), .cond_pass(pass)
    );

    logic [31:0] wa, wb, wres;
    logic        wshc, wsf, wwe, wpass;
    logic [3:0]  wop, wfin, wfout, wcond;

    alu_flag_core #(.WIDTH(32)) u1 (
        .opnd_a(wa), .opnd_b(wb), .shift_carry(wshc), .op(wop), .set_flags(wsf),
        .flags_in(wfin), .cond(wcond), .result(wres), .result_we(wwe),
        .flags_out(wfout), .cond_pass(wpass)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic cond_model(input int c, input logic [3:0] f);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && n == v;
            13: return z || n != v;
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        a = 0; b = 0; shc = 0; op = 0; sf = 0; fin = 0; cond = 4'd14;
        wa = 0; wb = 0; wshc = 0; wop = 0; wsf = 0; wfin = 0; wcond = 4'd14;
        @(negedge clk);
        // all-zero inputs: AND of zeros, no flag update
        chk("R1", "idle result", {60'd0, res}, 64'd0);
        chk("R4", "idle flags", {60'd0, fout}, 64'd0);
        chk("R1", "idle we", {63'd0, we}, 64'd1);

        // exhaustive sweep of opcodes and operands on the narrow instance
        for (int o = 0; o < 16; o++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int k = 0; k < 4; k++) begin
                        int  val, bx, ci, tot;
                        logic arith, cmpop, valid, upd, ec, ev;
                        logic [3:0] ef;
                        string rq;
                        @(posedge clk);
                        op = 4'(o); a = 4'(x); b = 4'(y);
                        fin = {k[0] ^ x[0], k[1] ^ y[0], k[0], k[0] ^ k[1]};
                        sf = k[1]; shc = x[1] ^ y[2]; cond = 4'd14;
                        #2;
                        arith = (o == 2 || o == 4 || o == 5 || o == 10);
                        cmpop = (o == 8 || o == 9 || o == 10);
                        valid = !(o == 3 || o == 6 || o == 7 || o == 11);
                        bx = y; ci = 0;
                        if (o == 2 || o == 10) begin bx = 15 - y; ci = 1; end
                        if (o == 5) ci = int'(fin[1]);
                        tot = x + bx + ci;
                        case (o)
                            0, 8: val = x & y;
                            1, 9: val = x ^ y;
                            12:   val = x | y;
                            13:   val = y;
                            14:   val = x & (15 - y);
                            15:   val = 15 - y;
                            2, 4, 5, 10: val = tot % 16;
                            default: val = 0;
                        endcase
                        ec = arith ? (tot >= 16) : shc;
                        ev = arith ? ((x >= 8) == (bx >= 8)) && ((val >= 8) != (x >= 8)) : fin[0];
                        upd = valid && (cmpop || sf);
                        ef = upd ? {val >= 8, val == 0, ec, ev} : fin;
                        rq = !valid ? "R10" : cmpop ? "R3" : arith ? "R2" : "R1";
                        if (valid) chk(rq, "result", {60'd0, res}, 64'(val));
                        chk(cmpop ? "R3" : "R10", "write enable", {63'd0, we}, 64'(valid && !cmpop));
                        chk(!upd ? "R4" : arith ? "R7" : "R6", "flags", {60'd0, fout}, {60'd0, ef});
                    end
                end
            end
        end

        // R8 and R9: every condition code against every flag pattern
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic ep;
                @(posedge clk);
                op = 4'd4; a = 4'd1; b = 4'd1; sf = 1'b1; shc = 1'b0;
                fin = 4'(f); cond = 4'(c);
                #2;
                ep = cond_model(c, 4'(f));
                chk("R8", "cond_pass", {63'd0, pass}, {63'd0, ep});
                chk("R9", "gated write", {63'd0, we}, {63'd0, ep});
                chk("R9", "gated flags", {60'd0, fout}, ep ? 64'd0 : 64'(f));
            end
        end

        // R1: bit clear on a full-width word
        @(posedge clk);
        wop = 4'd14; wa = 32'h02FA62CA; wb = 32'h0000FFFF; wsf = 0; wfin = 0;
        #2;
        chk("R1", "bic word", {32'd0, wres}, 64'h02FA0000);

        // R11: double-width addition through ADD then ADC
        begin
            logic [63:0] xa, xb, xs;
            logic [31:0] lo;
            xa = 64'h0000_0001_FFFF_FFFF;
            xb = 64'h0000_0002_0000_0001;
            xs = xa + xb;
            @(posedge clk);
            wop = 4'd4; wa = xa[31:0]; wb = xb[31:0]; wsf = 1; wfin = 0;
            #2;
            lo = wres;
            chk("R11", "low carry", {63'd0, wfout[1]}, 64'd1);
            @(posedge clk);
            wfin = wfout; wop = 4'd5; wa = xa[63:32]; wb = xb[63:32];
            #2;
            chk("R11", "chained sum", {wres, lo}, xs);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule